// File: doc/BRIEF.md
# Branch Target Address Generator

This unit produces the next program counter for jump and call instructions in a processor with 16-bit fixed-length instructions and a 24-bit address space. A target has one of two bases. A PC-relative target adds a displacement to the address of the following instruction. The displacement comes from a signed immediate or from a general-purpose register. An absolute target is loaded directly from a register or from a short immediate.

Short immediates can be widened by up to two prefix instructions that come just before the branch. The unit holds the prefix payloads itself. Each prefix is presented on a load strobe. When a non-prefix instruction issues, it uses the held payloads and then releases them.

The target is registered, so it appears one clock after the instruction is presented, together with a valid flag. Condition evaluation, instruction fetch and the register file sit outside this block.

Top module: `bta_top`

## Requirements
- R1: For kind 0 (relative immediate) with no prefix held, the target is pc + 2 + 2·sext(imm10). Here imm10 is the 10-bit two's-complement field `br_imm`.
- R2: For kind 1 (relative register), the target is pc + 2 + reg_val. The register value is added without shifting, and held prefixes have no effect.
- R3: Bit 0 of every produced target is 0.
- R4: For kind 3 (absolute register), the target is reg_val with bit 0 cleared. Held prefixes have no effect.
- R5: For kind 2 (absolute immediate) with no prefix held, the target is `br_imm[6:0]` zero-extended to 24 bits.
- R6: With one prefix held (payload P), the widened value is {P[12:0], br_imm[6:0]}, which is 20 bits. Kind 2 zero-extends it. Kind 0 sign-extends it from bit 19, doubles it and adds it to pc + 2.
- R7: With two prefixes held (first A, then B), the widened value is {A[3:0], B[12:0], br_imm[6:0]}, which is 24 bits. Kind 2 uses it directly. Kind 0 doubles it and adds it to pc + 2.
- R8: All address arithmetic wraps modulo 2^24.
- R9: An instruction strobe releases all held prefixes, whatever its kind. The next instruction sees no prefix.
- R10: A third prefix with no instruction in between keeps the two most recent payloads, in order of arrival.
- R11: `tgt_valid` is high for exactly the cycle after an instruction strobe. `tgt_addr` holds its value while no instruction is presented.
- R12: After reset, `tgt_valid` and `tgt_addr` are 0 and no prefix is held.
- R13: If a prefix strobe and an instruction strobe are high in the same cycle, the instruction is served with the prefixes already held and the new prefix is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pfx_load | input | 1 | A prefix instruction presents its payload |
| pfx_imm | input | 13 | Prefix payload |
| br_valid | input | 1 | A jump or call instruction is presented |
| br_kind | input | 2 | 0 rel-imm, 1 rel-reg, 2 abs-imm, 3 abs-reg |
| br_imm | input | 10 | Short immediate; low 7 bits are used when widened or for absolute targets |
| reg_val | input | 24 | General-purpose register operand |
| pc | input | 24 | Address of the branch instruction |
| tgt_valid | output | 1 | Target registered this cycle |
| tgt_addr | output | 24 | Aligned branch target |

## Verification
A stale or wrong prefix count changes the upper bits of the next immediate-based target. The wrong address appears on `tgt_addr` in the cycle after that instruction's strobe. A prefix register that is not released shows up the same way on the following instruction, and only on immediate kinds, because register kinds ignore the held payloads. A slip in the output register shows as a missing or extra `tgt_valid` pulse, or as `tgt_addr` moving in an idle cycle. Both are visible one cycle after the offending strobe.

// File: rtl/bta_pkg.sv
// Shared widths and the operand-kind encoding for the branch target unit.
package bta_pkg;
    localparam int ADDR_W  = 24;   // program counter width
    localparam int PFX_W   = 13;   // payload carried by one prefix instruction
    localparam int SHORT_W = 7;    // short immediate bits kept under a prefix
    localparam int DISP_W  = 10;   // unprefixed relative displacement width
    localparam int HI_W    = 4;    // bits taken from the first of two prefixes
    localparam int STEP    = 2;    // byte length of one instruction

    typedef enum logic [1:0] {
        K_REL_IMM = 2'd0,
        K_REL_REG = 2'd1,
        K_ABS_IMM = 2'd2,
        K_ABS_REG = 2'd3
    } br_kind_e;
endpackage

// File: rtl/bta_prefix_hold.sv
// Prefix holding register.
// Holds up to two prefix payloads in order of arrival, plus a count.
// Assumes the caller gives the instruction strobe priority over a prefix strobe
// in the same cycle; the instruction releases everything held.
module bta_prefix_hold #(
    parameter int PFX_W = bta_pkg::PFX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PFX_W-1:0] imm,
    input  logic             release_all,
    output logic [1:0]       cnt,
    output logic [PFX_W-1:0] first,
    output logic [PFX_W-1:0] second
);
    // Capture payloads, slide on overflow, clear on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= 2'd0;
            first  <= '0;
            second <= '0;
        end else if (release_all) begin
            cnt    <= 2'd0;
            first  <= '0;
            second <= '0;
        end else if (load) begin
            case (cnt)
                2'd0: begin
                    first <= imm;
                    cnt   <= 2'd1;
                end
                2'd1: begin
                    second <= imm;
                    cnt    <= 2'd2;
                end
                default: begin
                    first  <= second;
                    second <= imm;
                    cnt    <= 2'd2;
                end
            endcase
        end
    end
endmodule

// File: rtl/bta_imm_widen.sv
// Immediate widener.
// Forms the absolute immediate (zero-extended) and the relative displacement
// (sign-extended, then doubled) from the short field and the held prefixes.
// Assumes ADDR_W is at least the width of the two-prefix concatenation.
module bta_imm_widen #(
    parameter int ADDR_W  = bta_pkg::ADDR_W,
    parameter int PFX_W   = bta_pkg::PFX_W,
    parameter int SHORT_W = bta_pkg::SHORT_W,
    parameter int DISP_W  = bta_pkg::DISP_W,
    parameter int HI_W    = bta_pkg::HI_W
) (
    input  logic [1:0]        cnt,
    input  logic [PFX_W-1:0]  first,
    input  logic [PFX_W-1:0]  second,
    input  logic [DISP_W-1:0] short_imm,
    output logic [ADDR_W-1:0] abs_val,
    output logic [ADDR_W-1:0] rel_disp
);
    localparam int W1 = PFX_W + SHORT_W;
    localparam int W2 = HI_W + PFX_W + SHORT_W;

    logic [SHORT_W-1:0] low;
    logic [W1-1:0]      one_w;
    logic [W2-1:0]      two_w;
    logic [ADDR_W-1:0]  rel_raw;

    // Assemble the one- and two-prefix concatenations.
    always_comb begin
        low   = short_imm[SHORT_W-1:0];
        one_w = {first, low};
        two_w = {first[HI_W-1:0], second, low};
    end

    // Select the widened forms by the number of prefixes held.
    always_comb begin
        case (cnt)
            2'd0: begin
                abs_val = ADDR_W'(low);
                rel_raw = ADDR_W'($signed(short_imm));
            end
            2'd1: begin
                abs_val = ADDR_W'(one_w);
                rel_raw = ADDR_W'($signed(one_w));
            end
            default: begin
                abs_val = ADDR_W'(two_w);
                rel_raw = ADDR_W'($signed(two_w));
            end
        endcase
        rel_disp = rel_raw << 1;
    end
endmodule

// File: rtl/bta_target_calc.sv
// Target calculator.
// Adds the relative displacement to the next-instruction address, or passes
// an absolute value, then clears bit 0. The sum wraps at the address width.
module bta_target_calc #(
    parameter int ADDR_W = bta_pkg::ADDR_W,
    parameter int STEP   = bta_pkg::STEP
) (
    input  bta_pkg::br_kind_e kind,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] reg_val,
    input  logic [ADDR_W-1:0] abs_val,
    input  logic [ADDR_W-1:0] rel_disp,
    output logic [ADDR_W-1:0] target
);
    logic [ADDR_W-1:0] next_pc;
    logic [ADDR_W-1:0] raw;

    // Choose the operand and form the unaligned address.
    always_comb begin
        next_pc = pc + ADDR_W'(STEP);
        case (kind)
            bta_pkg::K_REL_IMM: raw = next_pc + rel_disp;
            bta_pkg::K_REL_REG: raw = next_pc + reg_val;
            bta_pkg::K_ABS_IMM: raw = abs_val;
            default:            raw = reg_val;
        endcase
    end

    // Force even alignment.
    always_comb begin
        target = {raw[ADDR_W-1:1], 1'b0};
    end
endmodule

// File: rtl/bta_top.sv
// Branch target address generator, top level.
// Holds the prefix payloads, widens the short immediate, computes the target
// and registers it one cycle after the instruction strobe.
// Assumes prefix instructions reach it before the branch they extend.
module bta_top #(
    parameter int ADDR_W = bta_pkg::ADDR_W,
    parameter int PFX_W  = bta_pkg::PFX_W,
    parameter int DISP_W = bta_pkg::DISP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pfx_load,
    input  logic [PFX_W-1:0]  pfx_imm,
    input  logic              br_valid,
    input  logic [1:0]        br_kind,
    input  logic [DISP_W-1:0] br_imm,
    input  logic [ADDR_W-1:0] reg_val,
    input  logic [ADDR_W-1:0] pc,
    output logic              tgt_valid,
    output logic [ADDR_W-1:0] tgt_addr
);
    logic [1:0]        pfx_cnt;
    logic [PFX_W-1:0]  pfx_first;
    logic [PFX_W-1:0]  pfx_second;
    logic [ADDR_W-1:0] abs_val;
    logic [ADDR_W-1:0] rel_disp;
    logic [ADDR_W-1:0] target;

    bta_prefix_hold #(.PFX_W(PFX_W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (pfx_load),
        .imm         (pfx_imm),
        .release_all (br_valid),
        .cnt         (pfx_cnt),
        .first       (pfx_first),
        .second      (pfx_second)
    );

    bta_imm_widen #(.ADDR_W(ADDR_W), .PFX_W(PFX_W), .DISP_W(DISP_W)) u_widen (
        .cnt       (pfx_cnt),
        .first     (pfx_first),
        .second    (pfx_second),
        .short_imm (br_imm),
        .abs_val   (abs_val),
        .rel_disp  (rel_disp)
    );

    bta_target_calc #(.ADDR_W(ADDR_W)) u_calc (
        .kind     (bta_pkg::br_kind_e'(br_kind)),
        .pc       (pc),
        .reg_val  (reg_val),
        .abs_val  (abs_val),
        .rel_disp (rel_disp),
        .target   (target)
    );

    // Register the target on an instruction strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_valid <= 1'b0;
            tgt_addr  <= '0;
        end else begin
            tgt_valid <= br_valid;
            if (br_valid) begin
                tgt_addr <= target;
            end
        end
    end
endmodule

// File: rtl/bta_chk.sv
// Assertion checker for bta_top, attached with bind.
module bta_chk #(
    parameter int ADDR_W = bta_pkg::ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              br_valid,
    input logic [1:0]        br_kind,
    input logic [ADDR_W-1:0] reg_val,
    input logic [ADDR_W-1:0] pc,
    input logic [1:0]        pfx_cnt,
    input logic              tgt_valid,
    input logic [ADDR_W-1:0] tgt_addr
);
    // R3
    even_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> (tgt_addr[0] == 1'b0));

    // R11
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> tgt_valid);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |=> (!tgt_valid && $stable(tgt_addr)));

    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> (pfx_cnt == 2'd0));

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pfx_cnt != 2'd3);

    // R2
    rel_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_kind == 2'd1) |=>
        (tgt_addr == ((($past(pc) + ADDR_W'(2)) + $past(reg_val)) & ~ADDR_W'(1))));

    // R4
    abs_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_kind == 2'd3) |=>
        (tgt_addr == ($past(reg_val) & ~ADDR_W'(1))));

    // R5
    abs_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_kind == 2'd2 && pfx_cnt == 2'd0) |=>
        (tgt_addr[ADDR_W-1:7] == '0));
endmodule

bind bta_top bta_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .br_valid  (br_valid),
    .br_kind   (br_kind),
    .reg_val   (reg_val),
    .pc        (pc),
    .pfx_cnt   (pfx_cnt),
    .tgt_valid (tgt_valid),
    .tgt_addr  (tgt_addr)
);

// File: tb/sim_bta_top.sv
module sim_bta_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pfx_load = 1'b0;
    logic [12:0] pfx_imm = '0;
    logic        br_valid = 1'b0;
    logic [1:0]  br_kind = '0;
    logic [9:0]  br_imm = '0;
    logic [23:0] reg_val = '0;
    logic [23:0] pc = '0;
    logic        tgt_valid;
    logic [23:0] tgt_addr;

    int n_chk = 0;
    int n_bad = 0;

    // bench model of the held prefixes
    int          m_cnt = 0;
    logic [12:0] m_a = '0;
    logic [12:0] m_b = '0;

    always #2.5 clk = ~clk;

    bta_top u0 (
        .clk(clk), .rst_n(rst_n), .pfx_load(pfx_load), .pfx_imm(pfx_imm),
        .br_valid(br_valid), .br_kind(br_kind), .br_imm(br_imm),
        .reg_val(reg_val), .pc(pc), .tgt_valid(tgt_valid), .tgt_addr(tgt_addr)
    );

    function automatic logic [23:0] expect_tgt(input logic [1:0] k, input logic [9:0] im,
            input logic [23:0] rv, input logic [23:0] p, input int c,
            input logic [12:0] a, input logic [12:0] b);
        logic [23:0] absv, disp, r;
        if (c == 0) begin
            absv = {17'd0, im[6:0]};
            disp = {{14{im[9]}}, im};
        end else if (c == 1) begin
            absv = {4'd0, a, im[6:0]};
            disp = {{4{a[12]}}, a, im[6:0]};
        end else begin
            absv = {a[3:0], b, im[6:0]};
            disp = absv;
        end
        case (k)
            2'd0: r = p + 24'd2 + (disp << 1);
            2'd1: r = p + 24'd2 + rv;
            2'd2: r = absv;
            default: r = rv;
        endcase
        return r & 24'hFFFFFE;
    endfunction

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_pfx(input logic [12:0] v);
        @(negedge clk);
        pfx_load = 1'b1;
        pfx_imm = v;
        @(negedge clk);
        pfx_load = 1'b0;
        if (m_cnt == 0) begin m_a = v; m_cnt = 1; end
        else if (m_cnt == 1) begin m_b = v; m_cnt = 2; end
        else begin m_a = m_b; m_b = v; end
    endtask

    // present one branch, check the registered result, then an idle cycle
    task automatic send_br(input string req, input logic [1:0] k, input logic [9:0] im,
            input logic [23:0] rv, input logic [23:0] p, input logic with_pfx);
        logic [23:0] e;
        @(negedge clk);
        br_valid = 1'b1; br_kind = k; br_imm = im; reg_val = rv; pc = p;
        pfx_load = with_pfx; pfx_imm = 13'h1ABC;
        e = expect_tgt(k, im, rv, p, m_cnt, m_a, m_b);
        @(negedge clk);
        br_valid = 1'b0; pfx_load = 1'b0;
        m_cnt = 0;
        check({req, " valid"}, {23'd0, tgt_valid}, 24'd1);
        check(req, tgt_addr, e);
        check("R3", {23'd0, tgt_addr[0]}, 24'd0);
        @(negedge clk);
        check("R11 idle valid", {23'd0, tgt_valid}, 24'd0);
        check("R11 hold", tgt_addr, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R11 watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 valid", {23'd0, tgt_valid}, 24'd0);
        check("R12 addr", tgt_addr, 24'd0);
        rst_n = 1'b1;

        send_br("R12 no prefix after reset", 2'd2, 10'h07F, 24'd0, 24'd0, 1'b0);
        send_br("R1 positive", 2'd0, 10'h005, 24'd0, 24'h001000, 1'b0);
        send_br("R1 negative", 2'd0, 10'h200, 24'd0, 24'h001000, 1'b0);
        send_br("R2 odd reg no shift", 2'd1, 10'h000, 24'h000011, 24'h000100, 1'b0);
        send_br("R8 wrap", 2'd1, 10'h000, 24'h000004, 24'hFFFFFE, 1'b0);
        send_br("R8 rel wrap low", 2'd0, 10'h3FF, 24'd0, 24'h000000, 1'b0);
        send_br("R4 abs reg odd", 2'd3, 10'h000, 24'hABCDEF, 24'd0, 1'b0);
        send_br("R5 abs short", 2'd2, 10'h3FF, 24'd0, 24'h123456, 1'b0);
        send_pfx(13'h1FFF);
        send_br("R6 one prefix abs", 2'd2, 10'h055, 24'd0, 24'd0, 1'b0);
        send_br("R9 released", 2'd2, 10'h055, 24'd0, 24'd0, 1'b0);
        send_pfx(13'h1000);
        send_br("R6 one prefix rel neg", 2'd0, 10'h001, 24'd0, 24'h400000, 1'b0);
        send_pfx(13'h0ABC); send_pfx(13'h1234);
        send_br("R7 two prefix abs", 2'd2, 10'h07F, 24'd0, 24'd0, 1'b0);
        send_pfx(13'h000F); send_pfx(13'h0001);
        send_br("R7 two prefix rel", 2'd0, 10'h003, 24'd0, 24'h000010, 1'b0);
        send_pfx(13'h0111); send_pfx(13'h0222); send_pfx(13'h0333);
        send_br("R10 third prefix", 2'd2, 10'h011, 24'd0, 24'd0, 1'b0);
        send_pfx(13'h0777);
        send_br("R2 prefix ignored", 2'd1, 10'h000, 24'h000020, 24'h000040, 1'b0);
        send_br("R9 after reg kind", 2'd2, 10'h011, 24'd0, 24'd0, 1'b0);
        send_pfx(13'h0777);
        send_br("R4 prefix ignored", 2'd3, 10'h000, 24'h00F00D, 24'd0, 1'b0);
        send_br("R13 same-cycle prefix", 2'd2, 10'h012, 24'd0, 24'd0, 1'b1);
        send_br("R13 dropped", 2'd2, 10'h012, 24'd0, 24'd0, 1'b0);

        for (int i = 0; i < 400; i++) begin
            int np;
            np = $urandom_range(0, 3);
            for (int j = 0; j < np; j++) send_pfx(13'($urandom));
            send_br("R1/R2/R4/R5/R6/R7 random", 2'($urandom), 10'($urandom),
                    24'($urandom), 24'($urandom), 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule